// File: doc/BRIEF.md
# Memory Access Watchpoint Interrupt Unit

This unit observes the access strobes of three on-chip memories: a general RAM (index 0), a data tightly coupled memory (index 1) and an instruction tightly coupled memory (index 2). On each memory it looks for two kinds of event:

- an access whose offset is at or beyond the allocated size supplied for that memory;
- an access that hits a programmable watch address in a chosen direction.

Events pass through a per-bit record mask into a sticky status register. Software clears that register by writing ones to it. A second per-bit mask selects which recorded bits raise the single interrupt line. The interrupt line is registered.

Software reaches the unit through a small register port. The port has a select, a write strobe and write data, and a read path with no wait state. The memories, the bus fabric and the allocation logic sit outside this unit. The allocation sizes arrive as inputs.

Top module: `mem_watch_irq`

## Requirements
- R1: After reset the status register, both masks and all three watch registers read as zero, and `irq` is low.
- R2: A valid access to memory m whose offset is greater than or equal to that memory's allocated size sets status bit m, provided record-mask bit m is set. An offset below the size sets nothing.
- R3: Watch register m (select 3+m) holds address bits [18:3] in its bits [16:1]. A valid access in the selected direction whose offset bits [18:3] equal that field sets status bit 3+m. Address bits [2:0] and bits above 18 take no part in the match. A watch register reads back its 17 bits, with zeros above them.
- R4: Watch bit 0 selects the direction: 0 matches reads (`accWrite`=0) and 1 matches writes. An access in the other direction never sets the match bit.
- R5: Writing the status register (select 0) clears each bit that is written as one. Bits written as zero keep their value.
- R6: The record mask (select 1, bits [5:0] in status order) blocks events whose mask bit is zero. Such events never reach the status register.
- R7: The signal mask (select 2, bits [5:0]) gates the interrupt. `irq` is the OR over the six bits of status AND signal mask, and it is updated one clock after them.
- R8: A status read returns the six event bits in [5:0] and zero in all other bits. The two mask registers keep and return only bits [5:0].
- R9: When an event and a write-one-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R10: While `accValid[m]` is low, memory m's address, direction and size inputs have no effect on status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset, asynchronous assert |
| regSel | input | 3 | Register select: 0 status, 1 record mask, 2 signal mask, 3..5 watch 0..2 |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Read data for `regSel`, combinational |
| accValid | input | 3 | Per-memory access strobe |
| accWrite | input | 3 | Per-memory direction, 1 for write |
| accAddr | input | 96 | Per-memory access offset, memory m in bits [32m+31:32m] |
| allocSize | input | 96 | Per-memory allocated size in bytes, same packing |
| irq | output | 1 | Registered interrupt request |

## Verification
An access or a register write presented before a rising edge updates the status and mask registers at that edge. The change is due on `regRdData` at the next falling edge. `irq` follows one edge later than the status and mask registers.

The bench drives every stimulus at a falling edge and holds it for one full cycle. It checks register contents at the falling edge that follows. For the interrupt, it checks both the cycle when `irq` must still hold its old value and the cycle after, so a design that is one clock early or one clock late fails.

// File: rtl/mwi_pkg.sv
package mwi_pkg;
  localparam int NUM_MEM  = 3;
  localparam int NUM_EVT  = 2 * NUM_MEM;
  localparam int REG_W    = 32;
  localparam int SEL_W    = 3;
  localparam int WATCH_W  = 17;
  localparam int WATCH_LO = 3;   // lowest address bit compared
  localparam int WATCH_HI = 18;  // highest address bit compared

  localparam logic [SEL_W-1:0] SEL_STATUS  = 3'd0;
  localparam logic [SEL_W-1:0] SEL_REC_EN  = 3'd1;
  localparam logic [SEL_W-1:0] SEL_SIG_EN  = 3'd2;
  localparam logic [SEL_W-1:0] SEL_WATCH0  = 3'd3;

  typedef struct packed {
    logic               clrStatus;
    logic               ldRecEn;
    logic               ldSigEn;
    logic [NUM_MEM-1:0] ldWatch;
    logic [REG_W-1:0]   data;
  } ctrl_strobe_t;
endpackage

// File: rtl/mwi_ctrl.sv
module mwi_ctrl
  import mwi_pkg::*;
(
  input  logic [SEL_W-1:0]           regSel,
  input  logic                       regWrEn,
  input  logic [REG_W-1:0]           regWrData,
  input  logic [NUM_EVT-1:0]         statusQ,
  input  logic [NUM_EVT-1:0]         recEnQ,
  input  logic [NUM_EVT-1:0]         sigEnQ,
  input  logic [NUM_MEM*WATCH_W-1:0] watchFlat,
  output ctrl_strobe_t               strobe,
  output logic [REG_W-1:0]           regRdData
);
  always_comb begin
    strobe           = '0;
    strobe.data      = regWrData;
    strobe.clrStatus = regWrEn && (regSel == SEL_STATUS);
    strobe.ldRecEn   = regWrEn && (regSel == SEL_REC_EN);
    strobe.ldSigEn   = regWrEn && (regSel == SEL_SIG_EN);
    for (int m = 0; m < NUM_MEM; m++)
      strobe.ldWatch[m] = regWrEn && (regSel == SEL_WATCH0 + SEL_W'(m));
  end

  always_comb begin
    regRdData = '0;
    case (regSel)
      SEL_STATUS: regRdData[NUM_EVT-1:0] = statusQ;
      SEL_REC_EN: regRdData[NUM_EVT-1:0] = recEnQ;
      SEL_SIG_EN: regRdData[NUM_EVT-1:0] = sigEnQ;
      default: begin
        for (int m = 0; m < NUM_MEM; m++)
          if (regSel == SEL_WATCH0 + SEL_W'(m))
            regRdData[WATCH_W-1:0] = watchFlat[m*WATCH_W +: WATCH_W];
      end
    endcase
  end

  // R8: upper status bits always read as zero
  always_comb begin
    if (regSel == SEL_STATUS)
      p_status_upper_zero_r8: assert (regRdData[REG_W-1:NUM_EVT] == '0);
  end
endmodule

// File: rtl/mwi_datapath.sv
module mwi_datapath
  import mwi_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ctrl_strobe_t               strobe,
  input  logic [NUM_MEM-1:0]         accValid,
  input  logic [NUM_MEM-1:0]         accWrite,
  input  logic [NUM_MEM*ADDR_W-1:0]  accAddr,
  input  logic [NUM_MEM*ADDR_W-1:0]  allocSize,
  output logic [NUM_EVT-1:0]         statusQ,
  output logic [NUM_EVT-1:0]         recEnQ,
  output logic [NUM_EVT-1:0]         sigEnQ,
  output logic [NUM_MEM*WATCH_W-1:0] watchFlat,
  output logic                       irq
);
  localparam int CMP_W = WATCH_HI - WATCH_LO + 1;

  logic [NUM_EVT-1:0] evtRaw;
  logic [NUM_EVT-1:0] evtKept;
  logic [NUM_EVT-1:0] clrMask;
  logic [NUM_EVT-1:0] statusD;
  logic [WATCH_W-1:0] watchQ [NUM_MEM];

  for (genvar m = 0; m < NUM_MEM; m++) begin : g_mem
    logic [ADDR_W-1:0] addr;
    logic [ADDR_W-1:0] size;
    logic              dirOk;
    logic              addrOk;

    assign addr   = accAddr[m*ADDR_W +: ADDR_W];
    assign size   = allocSize[m*ADDR_W +: ADDR_W];
    assign dirOk  = (accWrite[m] == watchQ[m][0]);
    assign addrOk = (addr[WATCH_HI:WATCH_LO] == watchQ[m][CMP_W:1]);

    assign evtRaw[m]         = accValid[m] && (addr >= size);
    assign evtRaw[NUM_MEM+m] = accValid[m] && dirOk && addrOk;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                 watchQ[m] <= '0;
      else if (strobe.ldWatch[m]) watchQ[m] <= strobe.data[WATCH_W-1:0];
    end

    assign watchFlat[m*WATCH_W +: WATCH_W] = watchQ[m];

    // R10: an idle port records nothing for its memory
    p_idle_no_set_r10: assert property (@(posedge clk) disable iff (!rstN)
      (!accValid[m] && !statusQ[m] && !statusQ[NUM_MEM+m]) |=>
        (!statusQ[m] && !statusQ[NUM_MEM+m]));
  end

  assign evtKept = evtRaw & recEnQ;
  assign clrMask = strobe.clrStatus ? strobe.data[NUM_EVT-1:0] : '0;
  assign statusD = (statusQ & ~clrMask) | evtKept;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ <= '0;
      recEnQ  <= '0;
      sigEnQ  <= '0;
      irq     <= 1'b0;
    end else begin
      statusQ <= statusD;
      if (strobe.ldRecEn) recEnQ <= strobe.data[NUM_EVT-1:0];
      if (strobe.ldSigEn) sigEnQ <= strobe.data[NUM_EVT-1:0];
      irq <= |(statusQ & sigEnQ);
    end
  end

  for (genvar b = 0; b < NUM_EVT; b++) begin : g_chk
    // R9: a kept event always lands, even against a clear
    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rstN)
      (evtRaw[b] && recEnQ[b]) |=> statusQ[b]);
    // R5: a bit drops only after a write-one-to-clear of it
    p_clear_needs_w1_r5: assert property (@(posedge clk) disable iff (!rstN)
      $fell(statusQ[b]) |-> $past(strobe.clrStatus && strobe.data[b]));
    // R6: a bit rises only if its record mask was set
    p_rise_needs_mask_r6: assert property (@(posedge clk) disable iff (!rstN)
      $rose(statusQ[b]) |-> $past(recEnQ[b]));
  end

  // R7: the interrupt needs some signal-mask bit one cycle earlier
  p_irq_needs_sig_r7: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> $past(sigEnQ != '0));
endmodule

// File: rtl/mem_watch_irq.sv
module mem_watch_irq
  import mwi_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [SEL_W-1:0]          regSel,
  input  logic                      regWrEn,
  input  logic [REG_W-1:0]          regWrData,
  output logic [REG_W-1:0]          regRdData,
  input  logic [NUM_MEM-1:0]        accValid,
  input  logic [NUM_MEM-1:0]        accWrite,
  input  logic [NUM_MEM*ADDR_W-1:0] accAddr,
  input  logic [NUM_MEM*ADDR_W-1:0] allocSize,
  output logic                      irq
);
  ctrl_strobe_t               strobe;
  logic [NUM_EVT-1:0]         statusQ;
  logic [NUM_EVT-1:0]         recEnQ;
  logic [NUM_EVT-1:0]         sigEnQ;
  logic [NUM_MEM*WATCH_W-1:0] watchFlat;

  mwi_ctrl u_ctrl (
    .regSel    (regSel),
    .regWrEn   (regWrEn),
    .regWrData (regWrData),
    .statusQ   (statusQ),
    .recEnQ    (recEnQ),
    .sigEnQ    (sigEnQ),
    .watchFlat (watchFlat),
    .strobe    (strobe),
    .regRdData (regRdData)
  );

  mwi_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .accValid  (accValid),
    .accWrite  (accWrite),
    .accAddr   (accAddr),
    .allocSize (allocSize),
    .statusQ   (statusQ),
    .recEnQ    (recEnQ),
    .sigEnQ    (sigEnQ),
    .watchFlat (watchFlat),
    .irq       (irq)
  );
endmodule

// File: tb/mem_watch_irq_bench.sv
`timescale 1ns/1ps
module mem_watch_irq_bench;
  localparam int AW = 32;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  regSel = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [2:0]  accValid = '0;
  logic [2:0]  accWrite = '0;
  logic [3*AW-1:0] accAddr = '0;
  logic [3*AW-1:0] allocSize = '0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  mem_watch_irq #(.ADDR_W(AW)) u_mem_watch_irq (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .accValid(accValid),
    .accWrite(accWrite), .accAddr(accAddr), .allocSize(allocSize), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [2:0] sel, input logic [31:0] d);
    @(negedge clk);
    regSel = sel; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [2:0] sel, output logic [31:0] v);
    regSel = sel;
    #1 v = regRdData;
  endtask

  task automatic access(input int m, input logic [31:0] a, input logic wr, input logic vld);
    @(negedge clk);
    accAddr[m*AW +: AW] = a; accWrite[m] = wr; accValid[m] = vld;
    @(negedge clk);
    accValid[m] = 1'b0;
  endtask

  task automatic clearAll();
    regWrite(3'd0, 32'h3F);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    @(negedge clk);
    for (int s = 0; s < 6; s++) begin
      regRead(3'(s), v);
      check("R1 reset register", v, 32'h0);
    end
    check("R1 reset irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_masks();
    logic [31:0] v;
    regWrite(3'd1, 32'hFFFF_FFFF);
    regRead(3'd1, v); check("R8 record mask width", v, 32'h3F);
    regWrite(3'd2, 32'hFFFF_FFC0);
    regRead(3'd2, v); check("R8 signal mask width", v, 32'h0);
  endtask

  task automatic t_alloc_error();
    logic [31:0] v;
    access(0, 32'h0FFF, 1'b0, 1'b1);
    regRead(3'd0, v); check("R2 below size", v, 32'h0);
    access(0, 32'h1000, 1'b1, 1'b1);
    regRead(3'd0, v); check("R2 at size mem0", v, 32'h01);
    access(2, 32'h0000_8000, 1'b0, 1'b1);
    regRead(3'd0, v); check("R2 beyond size mem2", v, 32'h05);
  endtask

  task automatic t_w1c();
    logic [31:0] v;
    regWrite(3'd0, 32'h0);
    regRead(3'd0, v); check("R5 write zero keeps", v, 32'h05);
    regWrite(3'd0, 32'h1);
    regRead(3'd0, v); check("R5 write one clears", v, 32'h04);
    clearAll();
    regRead(3'd0, v); check("R5 clear all", v, 32'h0);
  endtask

  task automatic t_watch();
    logic [31:0] v;
    // watch mem1 on writes at 0x1238 (bits 18:3 -> field 16:1)
    regWrite(3'd4, ((32'h1238 >> 3) << 1) | 32'h1);
    regRead(3'd4, v); check("R3 watch readback", v, ((32'h1238 >> 3) << 1) | 32'h1);
    regWrite(3'd5, 32'hFFFF_FFFF);
    regRead(3'd5, v); check("R3 watch width", v, 32'h1_FFFF);
    regWrite(3'd5, 32'h0);
    access(1, 32'h123F, 1'b1, 1'b1);
    regRead(3'd0, v); check("R3 same 8-byte word", v, 32'h10);
    clearAll();
    access(1, 32'h1238, 1'b0, 1'b1);
    regRead(3'd0, v); check("R4 opposite direction", v, 32'h0);
    access(1, 32'h1240, 1'b1, 1'b1);
    regRead(3'd0, v); check("R3 next word no match", v, 32'h0);
    access(1, 32'h0008_1238, 1'b1, 1'b1);
    regRead(3'd0, v); check("R3 high bits ignored", v, 32'h10);
    clearAll();
    // read-direction watch on mem0 at offset 0x40
    regWrite(3'd3, (32'h40 >> 3) << 1);
    access(0, 32'h40, 1'b1, 1'b1);
    regRead(3'd0, v); check("R4 write vs read watch", v, 32'h0);
    access(0, 32'h44, 1'b0, 1'b1);
    regRead(3'd0, v); check("R4 read watch hit", v, 32'h08);
    clearAll();
  endtask

  task automatic t_record_mask();
    logic [31:0] v;
    regWrite(3'd1, 32'h3E);
    access(0, 32'h2000, 1'b0, 1'b1);
    regRead(3'd0, v); check("R6 masked event dropped", v, 32'h0);
    access(2, 32'h9000, 1'b0, 1'b1);
    regRead(3'd0, v); check("R6 enabled event kept", v, 32'h04);
    regWrite(3'd1, 32'h3F);
    clearAll();
  endtask

  task automatic t_idle();
    logic [31:0] v;
    access(0, 32'hFFFF_0000, 1'b1, 1'b0);
    access(1, 32'h1238, 1'b1, 1'b0);
    regRead(3'd0, v); check("R10 idle port ignored", v, 32'h0);
  endtask

  task automatic t_irq();
    regWrite(3'd2, 32'h0);
    access(2, 32'h9000, 1'b0, 1'b1);
    @(negedge clk);
    check("R7 signal mask off", {31'b0, irq}, 32'h0);
    regWrite(3'd2, 32'h04);
    check("R7 not yet raised", {31'b0, irq}, 32'h0);
    @(negedge clk);
    check("R7 raised one cycle later", {31'b0, irq}, 32'h1);
    clearAll();
    check("R7 still high one cycle", {31'b0, irq}, 32'h1);
    @(negedge clk);
    check("R7 dropped after clear", {31'b0, irq}, 32'h0);
    regWrite(3'd2, 32'h0);
  endtask

  task automatic t_set_wins();
    logic [31:0] v;
    access(0, 32'h2000, 1'b0, 1'b1);
    @(negedge clk);
    regSel = 3'd0; regWrData = 32'h1; regWrEn = 1'b1;
    accAddr[0 +: AW] = 32'h3000; accWrite[0] = 1'b0; accValid[0] = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; accValid[0] = 1'b0;
    regRead(3'd0, v); check("R9 set beats clear", v, 32'h01);
    clearAll();
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual running expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    allocSize[0*AW +: AW] = 32'h0000_1000;
    allocSize[1*AW +: AW] = 32'h0010_0000;
    allocSize[2*AW +: AW] = 32'h0000_8000;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_masks();
    t_alloc_error();
    t_w1c();
    t_watch();
    t_record_mask();
    t_idle();
    t_irq();
    t_set_wins();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule